// File: doc/BRIEF.md
# Double-Rate Video Bus Capture and Pixel Demultiplexer

This block sits at the video input of a display transmitter. It takes a parallel pixel bus of up to 24 data pins, with a data-enable strobe and horizontal and vertical sync lines. The bus is sampled on both edges of the pixel clock. The two half-words captured in one clock period are merged in the rising-edge domain. The block then presents one aligned pixel per clock, with a valid flag. The syncs and the enable are delayed so that they stay lined up with that pixel.

Three static control inputs choose how a pixel is rebuilt: a format code, a component width code and a pin-assignment style code.

In the 4:2:2 luma/chroma mode, one component arrives on each edge. The rising edge carries chroma and the falling edge carries luma, with chroma alternating between Cb and Cr. Each output word holds one luma/chroma pair, and a flag tells Cb from Cr. In the 4:4:4 mode, each edge carries 12 bits of one 24-bit RGB (or YCbCr) pixel. Three pin layouts are available for this mode, and one of them reverses the order of the edges.

Top module: `ddr_video_capture`

## Requirements
- R1: While rst_n is low, every output (pix_data, pix_valid, pix_is_cr, pix_de, pix_hs, pix_vs) is zero.
- R2: With fmt_sel = 3'b100 (4:2:2), the component taken on the rising edge of clock period k is chroma, and the component taken on the falling edge of the same period is luma. After the rising edge of period k+1, pix_data = {luma, chroma}, with each value zero-extended in its own 12-bit field (luma in bits [23:12], chroma in bits [11:0]).
- R3: In 4:2:2 mode, the first rising-edge sample with DE high after a DE-low rising-edge sample is Cb (pix_is_cr = 0). Each later rising-edge sample with DE high flips between Cb and Cr. Rising-edge samples with DE low leave the order untouched.
- R4: In 4:2:2 mode with style_sel other than 2'b01 (split layout), component bits [msb:msb-7] are on pins [23:16]. The remaining low bits sit at the top of pins [15:12]: four bits on pins [15:12] for 12-bit width, two bits on pins [15:14] for 10-bit width, and none for 8-bit width.
- R5: In 4:2:2 mode with style_sel = 2'b01 (contiguous layout), the component sits on pins [w-1:0].
- R6: width_sel selects the component width: 2'b00 = 12 bits, 2'b01 = 10 bits, 2'b10 or 2'b11 = 8 bits. Pins outside the selected layout have no effect on pix_data.
- R7: With fmt_sel = 3'b101 (4:4:4) and style_sel 2'b00 or 2'b11, the rising edge carries {G[3:0], B[7:0]} on pins [11:0] and the falling edge carries {R[7:0], G[7:4]} on pins [11:0]. The output is pix_data = {R, G, B}.
- R8: In 4:4:4 mode with style_sel = 2'b01, the layout is the same as in R7 but on pins [23:12].
- R9: In 4:4:4 mode with style_sel = 2'b10, the edges are swapped: the rising edge carries {R, G[7:4]} and the falling edge carries {G[3:0], B}, both on pins [11:0].
- R10: pix_valid is 1 only when both the rising-edge and falling-edge DE samples of the pixel are high. While pix_valid is 0, pix_data and pix_is_cr are 0. pix_is_cr is always 0 in 4:4:4 mode.
- R11: pix_de, pix_hs and pix_vs equal the rising-edge samples of DE, HSYNC and VSYNC from the previous clock period. They appear in the same cycle as the pixel built from that period.
- R12: For any fmt_sel other than 3'b100 and 3'b101, pix_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; the bus is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_data | input | 24 | Parallel video data pins |
| pin_de | input | 1 | Data-enable strobe |
| pin_hs | input | 1 | Horizontal sync |
| pin_vs | input | 1 | Vertical sync |
| fmt_sel | input | 3 | Format code (3'b100 4:2:2, 3'b101 4:4:4) |
| width_sel | input | 2 | Component width code for 4:2:2 |
| style_sel | input | 2 | Pin-assignment style code |
| pix_data | output | 24 | Rebuilt pixel word |
| pix_valid | output | 1 | Pixel word holds active data |
| pix_is_cr | output | 1 | Chroma field is Cr (1) or Cb (0) |
| pix_de | output | 1 | Delayed data enable |
| pix_hs | output | 1 | Delayed horizontal sync |
| pix_vs | output | 1 | Delayed vertical sync |

## Verification
Lines of random components are driven in every format, width and style. The pins that a layout leaves unused are filled with random values, so a layout read from the wrong pins or with the wrong bit order shows up as a data mismatch. Lines start and stop with DE dips. Short dips in the middle of a line show whether the Cb/Cr order realigns on DE rising, rather than running freely. Random cycles where only the falling-edge DE sample drops separate the two-edge valid rule from a valid taken from the rising edge alone. Random syncs, with different values driven during the falling half, check that only the rising-edge samples are forwarded. Runs with unused format codes confirm that nothing is marked valid.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;

   // format codes
   localparam logic [2:0] FMT_YC422  = 3'b100;
   localparam logic [2:0] FMT_RGB444 = 3'b101;

   // component width codes (4:2:2 only)
   localparam logic [1:0] WID_12 = 2'b00;
   localparam logic [1:0] WID_10 = 2'b01;

   // pin-assignment style codes
   localparam logic [1:0] STY_A = 2'b00;
   localparam logic [1:0] STY_B = 2'b01;
   localparam logic [1:0] STY_C = 2'b10;

   // sync bundle captured on the rising edge
   typedef struct packed {
      logic de;
      logic hs;
      logic vs;
   } sync_t;

endpackage

// File: rtl/ddr_edge_sampler.sv
module ddr_edge_sampler #(
   parameter int RISE_W = 27,
   parameter int FALL_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RISE_W-1:0] d_rise,
   input  logic [FALL_W-1:0] d_fall,
   output logic [RISE_W-1:0] q_rise,
   output logic [FALL_W-1:0] q_fall
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_rise <= '0;
      else        q_rise <= d_rise;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) q_fall <= '0;
      else        q_fall <= d_fall;
   end

endmodule

// File: rtl/ddr_comp_unpack.sv
module ddr_comp_unpack
   import ddr_cap_pkg::*;
#(
   parameter int PIN_W     = 24,
   parameter int CW        = 12,
   parameter int S1_HI_LSB = 16,
   parameter int S1_LO_MSB = 15,
   parameter int S2_LSB    = 0
) (
   input  logic [PIN_W-1:0] word,
   input  logic [1:0]       width_sel,
   input  logic [1:0]       style_sel,
   output logic [CW-1:0]    comp
);

   localparam int HI_W = 8;
   localparam int LO_W = CW - HI_W;

   logic [HI_W-1:0] hi_grp;
   logic [LO_W-1:0] lo_grp;
   logic [CW-1:0]   flat;
   logic [CW-1:0]   mask;
   logic [CW-1:0]   split_val;
   logic            unused_pins;

   assign hi_grp      = word[S1_HI_LSB +: HI_W];
   assign lo_grp      = word[S1_LO_MSB -: LO_W];
   assign flat        = word[S2_LSB +: CW];
   assign unused_pins = ^word;

   always_comb begin
      case (width_sel)
         WID_12: begin
            mask      = {CW{1'b1}};
            split_val = {hi_grp, lo_grp};
         end
         WID_10: begin
            mask      = {{2{1'b0}}, {(CW-2){1'b1}}};
            split_val = {2'b00, hi_grp, lo_grp[LO_W-1 -: 2]};
         end
         default: begin
            mask      = {{LO_W{1'b0}}, {HI_W{1'b1}}};
            split_val = {{LO_W{1'b0}}, hi_grp};
         end
      endcase
   end

   assign comp = (style_sel == STY_B) ? (flat & mask) : split_val;

endmodule

// File: rtl/ddr_rgb_join.sv
module ddr_rgb_join
   import ddr_cap_pkg::*;
#(
   parameter int PIN_W      = 24,
   parameter int SLOT_W     = 12,
   parameter int RGB_LO_LSB = 0,
   parameter int RGB_HI_LSB = 12
) (
   input  logic [PIN_W-1:0]    first_word,
   input  logic [PIN_W-1:0]    second_word,
   input  logic [1:0]          style_sel,
   output logic [2*SLOT_W-1:0] rgb
);

   logic [SLOT_W-1:0] slot_a;
   logic [SLOT_W-1:0] slot_b;
   logic [SLOT_W-1:0] lead;   // {G low, B}
   logic [SLOT_W-1:0] trail;  // {R, G high}
   logic              unused_pins;

   assign unused_pins = ^{first_word, second_word};

   always_comb begin
      if (style_sel == STY_B) begin
         slot_a = first_word[RGB_HI_LSB +: SLOT_W];
         slot_b = second_word[RGB_HI_LSB +: SLOT_W];
      end else begin
         slot_a = first_word[RGB_LO_LSB +: SLOT_W];
         slot_b = second_word[RGB_LO_LSB +: SLOT_W];
      end
      if (style_sel == STY_C) begin
         lead  = slot_b;
         trail = slot_a;
      end else begin
         lead  = slot_a;
         trail = slot_b;
      end
   end

   // {R, G, B}
   assign rgb = {trail[SLOT_W-1:4], trail[3:0], lead[SLOT_W-1:8], lead[7:0]};

endmodule

// File: rtl/ddr_video_capture.sv
module ddr_video_capture
   import ddr_cap_pkg::*;
#(
   parameter int PIN_W      = 24,
   parameter int CW         = 12,
   parameter int S1_HI_LSB  = 16,
   parameter int S1_LO_MSB  = 15,
   parameter int S2_LSB     = 0,
   parameter int RGB_LO_LSB = 0,
   parameter int RGB_HI_LSB = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pin_data,
   input  logic              pin_de,
   input  logic              pin_hs,
   input  logic              pin_vs,
   input  logic [2:0]        fmt_sel,
   input  logic [1:0]        width_sel,
   input  logic [1:0]        style_sel,
   output logic [2*CW-1:0]   pix_data,
   output logic              pix_valid,
   output logic              pix_is_cr,
   output logic              pix_de,
   output logic              pix_hs,
   output logic              pix_vs
);

   localparam int SYNC_W = $bits(sync_t);
   localparam int RISE_W = PIN_W + SYNC_W;
   localparam int FALL_W = PIN_W + 1;
   localparam int OUT_W  = 2 * CW;
   localparam int SLOT_W = OUT_W / 2;

   generate
      if (CW != 12) begin : g_bad_cw
         $error("CW must be 12");
      end
      if (PIN_W < 24) begin : g_bad_pins
         $error("PIN_W must be at least 24");
      end
      if (S1_HI_LSB + 8 > PIN_W || S1_LO_MSB >= PIN_W || S1_LO_MSB < CW - 9) begin : g_bad_split
         $error("split layout outside the pin bus");
      end
      if (S2_LSB + CW > PIN_W) begin : g_bad_flat
         $error("contiguous layout outside the pin bus");
      end
      if (RGB_LO_LSB + SLOT_W > PIN_W || RGB_HI_LSB + SLOT_W > PIN_W) begin : g_bad_rgb
         $error("4:4:4 slot outside the pin bus");
      end
   endgenerate

   // ---------------- edge capture ----------------
   sync_t             sync_in;
   logic [RISE_W-1:0] rise_q;
   logic [FALL_W-1:0] fall_q;
   logic [PIN_W-1:0]  half_w [2];
   sync_t             sync_r;
   logic              de_f;

   assign sync_in = '{de: pin_de, hs: pin_hs, vs: pin_vs};

   ddr_edge_sampler #(
      .RISE_W (RISE_W),
      .FALL_W (FALL_W)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_rise ({sync_in, pin_data}),
      .d_fall ({pin_de, pin_data}),
      .q_rise (rise_q),
      .q_fall (fall_q)
   );

   assign half_w[0] = rise_q[PIN_W-1:0];
   assign sync_r    = rise_q[RISE_W-1:PIN_W];
   assign half_w[1] = fall_q[PIN_W-1:0];
   assign de_f      = fall_q[FALL_W-1];

   // ---------------- 4:2:2 component extraction per edge ----------------
   logic [CW-1:0] comp [2];

   generate
      for (genvar e = 0; e < 2; e++) begin : g_edge
         ddr_comp_unpack #(
            .PIN_W     (PIN_W),
            .CW        (CW),
            .S1_HI_LSB (S1_HI_LSB),
            .S1_LO_MSB (S1_LO_MSB),
            .S2_LSB    (S2_LSB)
         ) u_unpack (
            .word      (half_w[e]),
            .width_sel (width_sel),
            .style_sel (style_sel),
            .comp      (comp[e])
         );
      end
   endgenerate

   // ---------------- 4:4:4 join ----------------
   logic [OUT_W-1:0] rgb;

   ddr_rgb_join #(
      .PIN_W      (PIN_W),
      .SLOT_W     (SLOT_W),
      .RGB_LO_LSB (RGB_LO_LSB),
      .RGB_HI_LSB (RGB_HI_LSB)
   ) u_join (
      .first_word  (half_w[0]),
      .second_word (half_w[1]),
      .style_sel   (style_sel),
      .rgb         (rgb)
   );

   // ---------------- chroma phase ----------------
   logic phase_cr_q;
   logic prev_de_q;
   logic cur_cr;

   assign cur_cr = (sync_r.de && !prev_de_q) ? 1'b0 : phase_cr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_cr_q <= 1'b0;
         prev_de_q  <= 1'b0;
      end else begin
         prev_de_q <= sync_r.de;
         if (sync_r.de) phase_cr_q <= !cur_cr;
      end
   end

   // ---------------- output stage ----------------
   logic             is_422;
   logic             is_444;
   logic             nxt_valid;
   logic [OUT_W-1:0] nxt_data;

   assign is_422    = (fmt_sel == FMT_YC422);
   assign is_444    = (fmt_sel == FMT_RGB444);
   assign nxt_valid = (is_422 || is_444) && sync_r.de && de_f;

   always_comb begin
      if (!nxt_valid)  nxt_data = '0;
      else if (is_422) nxt_data = {comp[1], comp[0]};
      else             nxt_data = rgb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_data  <= '0;
         pix_valid <= 1'b0;
         pix_is_cr <= 1'b0;
         pix_de    <= 1'b0;
         pix_hs    <= 1'b0;
         pix_vs    <= 1'b0;
      end else begin
         pix_data  <= nxt_data;
         pix_valid <= nxt_valid;
         pix_is_cr <= nxt_valid && is_422 && cur_cr;
         pix_de    <= sync_r.de;
         pix_hs    <= sync_r.hs;
         pix_vs    <= sync_r.vs;
      end
   end

endmodule

// File: rtl/ddr_video_capture_chk.sv
module ddr_video_capture_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        pin_de,
   input logic        pin_hs,
   input logic        pin_vs,
   input logic [2:0]  fmt_sel,
   input logic [23:0] pix_data,
   input logic        pix_valid,
   input logic        pix_is_cr,
   input logic        pix_hs,
   input logic        pix_vs
);

   logic [1:0] since_rst;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign armed = (since_rst == 2'd3);

   // R10
   invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (pix_data == 24'd0 && !pix_is_cr));

   // R10
   valid_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pix_valid) |-> $past(pin_de, 2));

   // R11
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (pix_hs == $past(pin_hs, 2) && pix_vs == $past(pin_vs, 2)));

   // R12
   bad_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(fmt_sel) != 3'b100 && $past(fmt_sel) != 3'b101) |-> !pix_valid);

   // R3
   chroma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pix_valid && $past(pix_valid) && $past(fmt_sel) == 3'b100
       && $past(fmt_sel, 2) == 3'b100) |-> (pix_is_cr != $past(pix_is_cr)));

endmodule

bind ddr_video_capture ddr_video_capture_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_de    (pin_de),
   .pin_hs    (pin_hs),
   .pin_vs    (pin_vs),
   .fmt_sel   (fmt_sel),
   .pix_data  (pix_data),
   .pix_valid (pix_valid),
   .pix_is_cr (pix_is_cr),
   .pix_hs    (pix_hs),
   .pix_vs    (pix_vs)
);

// File: tb/tb_ddr_video_capture.sv
module tb_ddr_video_capture;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] pin_data = '0;
   logic        pin_de = 1'b0, pin_hs = 1'b0, pin_vs = 1'b0;
   logic [2:0]  fmt_sel = 3'b100;
   logic [1:0]  width_sel = 2'b00, style_sel = 2'b00;
   logic [23:0] pix_data;
   logic        pix_valid, pix_is_cr, pix_de, pix_hs, pix_vs;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_video_capture dut (
      .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_de(pin_de),
      .pin_hs(pin_hs), .pin_vs(pin_vs), .fmt_sel(fmt_sel),
      .width_sel(width_sel), .style_sel(style_sel), .pix_data(pix_data),
      .pix_valid(pix_valid), .pix_is_cr(pix_is_cr), .pix_de(pix_de),
      .pix_hs(pix_hs), .pix_vs(pix_vs)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- reference packers ----------------
   function automatic int wbits(input logic [1:0] w);
      return (w == 2'b00) ? 12 : (w == 2'b01) ? 10 : 8;
   endfunction

   function automatic logic [23:0] pack_yc(input logic [11:0] c, input logic [1:0] w,
                                           input logic [1:0] s, input logic [23:0] noise);
      logic [23:0] r = noise;
      int nb = wbits(w);
      if (s == 2'b01) begin
         for (int i = 0; i < nb; i++) r[i] = c[i];
      end else begin
         for (int i = 0; i < 8; i++) r[16+i] = c[nb-8+i];
         for (int k = 0; k < nb-8; k++) r[16-(nb-8)+k] = c[k];
      end
      return r;
   endfunction

   // ---------------- model state and pending expectation ----------------
   bit          m_phase = 0, m_prev_de = 0;
   bit          p_have = 0;
   logic [23:0] p_data;
   logic        p_valid, p_cr, p_de, p_hs, p_vs;
   string       p_req;

   task automatic send(input logic [23:0] a, input logic [23:0] b, input logic da,
                       input logic db, input logic hs, input logic vs,
                       input logic [23:0] vdata, input string req);
      logic ecr = 1'b0;
      logic ev;
      if (da) begin
         ecr = m_prev_de ? m_phase : 1'b0;
         m_phase = !ecr;
      end
      m_prev_de = da;
      ev = (fmt_sel == 3'b100 || fmt_sel == 3'b101) && da && db;
      pin_data = a; pin_de = da; pin_hs = hs; pin_vs = vs;
      @(posedge clk); #2;
      pin_data = b; pin_de = db; pin_hs = $urandom; pin_vs = $urandom;
      @(negedge clk); #2;
      if (p_have) begin
         chk({p_req, " data"}, {8'd0, pix_data}, {8'd0, p_data});
         chk("R10 valid", {31'd0, pix_valid}, {31'd0, p_valid});
         chk("R3 chroma flag", {31'd0, pix_is_cr}, {31'd0, p_cr});
         chk("R11 syncs", {29'd0, pix_de, pix_hs, pix_vs}, {29'd0, p_de, p_hs, p_vs});
      end
      p_have  = 1;
      p_valid = ev;
      p_data  = ev ? vdata : 24'd0;
      p_cr    = ev && (fmt_sel == 3'b100) && ecr;
      p_de = da; p_hs = hs; p_vs = vs;
      p_req = req;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++)
         send($urandom, $urandom, 1'b0, 1'b0, $urandom, $urandom, 24'd0, "R10");
   endtask

   task automatic line_422(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         int nb = wbits(width_sel);
         logic [11:0] c = 12'($urandom) & 12'((1 << nb) - 1);
         logic [11:0] y = 12'($urandom) & 12'((1 << nb) - 1);
         logic db = ($urandom % 8) != 0;
         if ($urandom % 10 == 0) begin
            idle(1);
         end
         send(pack_yc(c, width_sel, style_sel, $urandom), pack_yc(y, width_sel, style_sel, $urandom),
              1'b1, db, $urandom, $urandom, {y, c}, req);
      end
   endtask

   task automatic line_444(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         logic [7:0] r = $urandom, g = $urandom, b = $urandom;
         logic [11:0] lead = {g[3:0], b};
         logic [11:0] trail = {r, g[7:4]};
         logic [23:0] wa = $urandom, wb = $urandom;
         logic db = ($urandom % 8) != 0;
         case (style_sel)
            2'b01: begin wa[23:12] = lead;  wb[23:12] = trail; end
            2'b10: begin wa[11:0]  = trail; wb[11:0]  = lead;  end
            default: begin wa[11:0] = lead; wb[11:0]  = trail; end
         endcase
         send(wa, wb, 1'b1, db, $urandom, $urandom, {r, g, b}, req);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      chk("R1 reset", {26'd0, pix_data == 24'd0, pix_valid, pix_is_cr, pix_de, pix_hs, pix_vs}, 32'h20);
      rst_n = 1'b1;

      // directed: first Cb, then Cr, 12-bit split layout
      fmt_sel = 3'b100; width_sel = 2'b00; style_sel = 2'b00;
      idle(2);
      send(pack_yc(12'hABC, 2'b00, 2'b00, 24'h0), pack_yc(12'h123, 2'b00, 2'b00, 24'h0),
           1'b1, 1'b1, 1'b1, 1'b0, 24'h123ABC, "R2 R4");
      send(pack_yc(12'h456, 2'b00, 2'b00, 24'hFFFFFF), pack_yc(12'h789, 2'b00, 2'b00, 24'hFFFFFF),
           1'b1, 1'b1, 1'b0, 1'b1, 24'h789456, "R2 R4");
      idle(2);

      // 4:2:2 sweep over widths and styles
      for (int s = 0; s < 4; s++) begin
         for (int w = 0; w < 4; w++) begin
            width_sel = 2'(w); style_sel = 2'(s);
            line_422(14, (s == 1) ? "R5 R6" : "R4 R6");
            idle(2);
         end
      end

      // 4:4:4 sweep over styles
      fmt_sel = 3'b101;
      for (int s = 0; s < 4; s++) begin
         style_sel = 2'(s);
         width_sel = 2'($urandom);
         line_444(20, (s == 1) ? "R8" : (s == 2) ? "R9" : "R7");
         idle(2);
      end

      // directed: falling DE low in 4:4:4 gives no valid
      style_sel = 2'b00;
      send(24'h000ABC, 24'h000DEF, 1'b1, 1'b0, 1'b0, 1'b0, 24'h0, "R10");
      idle(1);

      // unused format codes
      for (int f = 0; f < 8; f++) begin
         if (f == 4 || f == 5) continue;
         fmt_sel = 3'(f);
         line_444(4, "R12");
         idle(1);
      end
      fmt_sel = 3'b100;
      idle(2);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule